// File: doc/BRIEF.md
# Interrupt Gate Dispatch Controller

This block decides, cycle by cycle, whether an incoming interrupt request is taken and how it is serviced. Four request kinds compete: exceptions (which may carry an error code), the non-maskable interrupt, the maskable interrupt and software interrupts. The gate type for the request comes already resolved from a vector lookup outside the block. Interrupt and trap gates produce a procedure-style entry, shown as push strobes for the flags, code segment and instruction pointer. A task gate produces a full task switch against an internal table of per-task saved state.

The block holds the interrupt enable flag, the nested-task flag, the NMI block flag and the current task number. Each of eight task slots keeps a saved state word, a saved nested-task flag and a back link to the task it interrupted. A return request is taken as a procedure return when the nested-task flag is clear. When the flag is set, the return switches back to the task named in the back link. The state given at that return is saved, so a later re-entry of the task resumes from it.

All outputs are registered. A request presented in a cycle shows its result one clock later.

Top module: `irq_dispatch_ctrl`

## Requirements
- R1: At most one request is granted per cycle, with priority exception > NMI > INTR > software. `src_o` reports the granted kind as 0 = exception, 1 = NMI, 2 = INTR, 3 = software, and is 0 when nothing is granted.
- R2: INTR is granted only while `ie_o` is 1. Exceptions and software interrupts are granted regardless of `ie_o` and `nmi_blk_o`.
- R3: `gate_type_i` encodes 0 = interrupt gate, 1 = trap gate, 2 = task gate; 3 behaves as an interrupt gate. A grant through code 0 or 3 clears `ie_o`. A grant through a trap or task gate leaves `ie_o` unchanged.
- R4: Granting an NMI sets `nmi_blk_o`. While `nmi_blk_o` is 1, NMI requests are not granted.
- R5: A grant through an interrupt or trap gate sets `action_o` = 1 and pulses `push_flags_o`, `push_cs_o` and `push_ip_o` together for one cycle, with `load_valid_o` = 0.
- R6: A grant through a task gate sets `action_o` = 2. It saves `cur_state_i` and the nested-task flag into the current task's slot, and puts the target slot's saved state on `load_state_o` with `load_valid_o` = 1. It then makes the target current, sets `nt_o`, and records the old task in the target's back link, which `back_link_o` shows.
- R7: A granted exception with `exc_has_err_i` = 1 pulses `push_err_o` with `err_val_o` = `exc_err_i`. `err_new_stack_o` is 1 for a task gate (the push lands on the new task's stack) and 0 otherwise. `err_val_o` is 0 when no code is pushed.
- R8: A return with `nt_o` = 0 sets `action_o` = 3, pulses `pop_frame_o`, and loads `ie_o` from `pop_ie_i`. `nmi_blk_o` clears only when the return leaves the nesting level that the NMI entered.
- R9: A return with `nt_o` = 1 sets `action_o` = 4. It saves `cur_state_i` into the current slot, switches to the back-linked task, loads that slot's state, and restores `nt_o` from that task's saved flag.
- R10: A task re-entered after it returned resumes from the state given at its last return, not from its entry state.
- R11: A task-gate request whose target equals the current task pulses `self_err_o`. Nothing is granted and no flag, task or table state changes.
- R12: A return request is ignored in any cycle in which a request is granted or rejected with `self_err_o`.
- R13: After reset `ie_o`, `nt_o`, `nmi_blk_o`, `cur_task_o` and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exc_req_i | input | 1 | Exception request |
| exc_has_err_i | input | 1 | Exception carries an error code |
| exc_err_i | input | EW | Error code value |
| nmi_req_i | input | 1 | Non-maskable interrupt request |
| intr_req_i | input | 1 | Maskable interrupt request |
| swi_req_i | input | 1 | Software interrupt request |
| gate_type_i | input | 2 | Resolved gate type for the request |
| gate_task_i | input | TW | Target task of a task gate |
| iret_i | input | 1 | Return request |
| pop_ie_i | input | 1 | Enable flag value in the popped flags |
| cur_state_i | input | SW | Register state of the running task |
| grant_o | output | 1 | Request granted last cycle |
| src_o | output | 2 | Kind of granted request |
| action_o | output | 3 | 0 none, 1 gate entry, 2 task entry, 3 procedure return, 4 task return |
| push_flags_o | output | 1 | Push flags strobe |
| push_cs_o | output | 1 | Push code segment strobe |
| push_ip_o | output | 1 | Push instruction pointer strobe |
| push_err_o | output | 1 | Push error code strobe |
| err_new_stack_o | output | 1 | Error code goes to the new task's stack |
| err_val_o | output | EW | Error code pushed |
| pop_frame_o | output | 1 | Procedure return frame pop strobe |
| load_valid_o | output | 1 | Task state load strobe |
| load_state_o | output | SW | State loaded for the incoming task |
| self_err_o | output | 1 | Task gate targeted the running task |
| ie_o | output | 1 | Interrupt enable flag |
| nt_o | output | 1 | Nested-task flag of the running task |
| nmi_blk_o | output | 1 | NMI block flag |
| cur_task_o | output | TW | Running task number |
| back_link_o | output | TW | Back link of the running task |

## Verification
The hardest case to reach is clearing the NMI block at the right nesting level. An exception has to be taken inside the NMI handler, and its return must leave the block set. Only the next return, which leaves the NMI handler, may clear it. A directed sequence builds this nesting on purpose. It also covers a task round trip: switch out, return with a new state, then re-enter and check that the later state comes back. Random stimulus mixes returns with task gates to random targets. Chained switches, self-target rejections and nested-task returns therefore occur often, and a bench model checks them.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;
  localparam int NSRC = 4;

  localparam logic [1:0] SRC_EXC  = 2'd0;
  localparam logic [1:0] SRC_NMI  = 2'd1;
  localparam logic [1:0] SRC_INTR = 2'd2;
  localparam logic [1:0] SRC_SWI  = 2'd3;

  localparam logic [1:0] GATE_INT  = 2'd0;
  localparam logic [1:0] GATE_TRAP = 2'd1;
  localparam logic [1:0] GATE_TASK = 2'd2;

  localparam logic [2:0] ACT_NONE = 3'd0;
  localparam logic [2:0] ACT_GATE = 3'd1;
  localparam logic [2:0] ACT_TASK = 3'd2;
  localparam logic [2:0] ACT_PRET = 3'd3;
  localparam logic [2:0] ACT_TRET = 3'd4;
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_disp_pkg::*;
#(
  parameter int TW = 3
) (
  input  logic          exc_i,
  input  logic          nmi_i,
  input  logic          intr_i,
  input  logic          swi_i,
  input  logic          ie_i,
  input  logic          nmi_blk_i,
  input  logic [1:0]    gate_i,
  input  logic [TW-1:0] tgt_i,
  input  logic [TW-1:0] cur_i,
  output logic          pick_o,
  output logic [1:0]    src_o,
  output logic          self_err_o,
  output logic          accept_o
);
  logic [NSRC-1:0] ok;

  always_comb begin
    ok           = '0;
    ok[SRC_EXC]  = exc_i;
    ok[SRC_NMI]  = nmi_i & ~nmi_blk_i;
    ok[SRC_INTR] = intr_i & ie_i;
    ok[SRC_SWI]  = swi_i;
  end

  // lowest index wins
  always_comb begin
    pick_o = 1'b0;
    src_o  = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (ok[i]) begin
        pick_o = 1'b1;
        src_o  = 2'(i);
      end
    end
  end

  assign self_err_o = pick_o && (gate_i == GATE_TASK) && (tgt_i == cur_i);
  assign accept_o   = pick_o && !self_err_o;
endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track #(
  parameter int DW = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enter_i,
  input  logic nmi_enter_i,
  input  logic leave_i,
  output logic nmi_blk_o
);
  localparam logic [DW-1:0] DMAX = '1;

  logic [DW-1:0] depth_q, mark_q;
  logic          blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      mark_q  <= '0;
      blk_q   <= 1'b0;
    end else if (enter_i) begin
      if (depth_q != DMAX) depth_q <= depth_q + 1'b1;
      if (nmi_enter_i) begin
        blk_q  <= 1'b1;
        mark_q <= depth_q;
      end
    end else if (leave_i) begin
      if (depth_q != '0) depth_q <= depth_q - 1'b1;
      // leaving the level the NMI handler runs at
      if (blk_q && (depth_q == DW'(mark_q + 1'b1))) blk_q <= 1'b0;
    end
  end

  assign nmi_blk_o = blk_q;
endmodule

// File: rtl/irq_task_table.sv
module irq_task_table #(
  parameter int NTASK = 8,
  parameter int SW    = 16,
  localparam int TW   = $clog2(NTASK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          s_we_i,
  input  logic [TW-1:0] s_idx_i,
  input  logic [SW-1:0] s_state_i,
  input  logic          s_nt_i,
  input  logic          l_we_i,
  input  logic [TW-1:0] l_idx_i,
  input  logic [TW-1:0] l_val_i,
  input  logic [TW-1:0] a_idx_i,
  output logic [SW-1:0] a_state_o,
  output logic          a_nt_o,
  input  logic [TW-1:0] b_idx_i,
  output logic [TW-1:0] b_link_o
);
  logic [SW-1:0] st_arr   [NTASK];
  logic          nt_arr   [NTASK];
  logic [TW-1:0] link_arr [NTASK];

  for (genvar g = 0; g < NTASK; g++) begin : gen_slot
    logic [SW-1:0] st_q;
    logic          nt_q;
    logic [TW-1:0] link_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q   <= '0;
        nt_q   <= 1'b0;
        link_q <= '0;
      end else begin
        if (s_we_i && (s_idx_i == TW'(g))) begin
          st_q <= s_state_i;
          nt_q <= s_nt_i;
        end
        if (l_we_i && (l_idx_i == TW'(g))) link_q <= l_val_i;
      end
    end

    assign st_arr[g]   = st_q;
    assign nt_arr[g]   = nt_q;
    assign link_arr[g] = link_q;
  end

  assign a_state_o = st_arr[a_idx_i];
  assign a_nt_o    = nt_arr[a_idx_i];
  assign b_link_o  = link_arr[b_idx_i];
endmodule

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import irq_disp_pkg::*;
#(
  parameter int NTASK = 8,
  parameter int SW    = 16,
  parameter int EW    = 16,
  parameter int DW    = 4,
  localparam int TW   = $clog2(NTASK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exc_req_i,
  input  logic          exc_has_err_i,
  input  logic [EW-1:0] exc_err_i,
  input  logic          nmi_req_i,
  input  logic          intr_req_i,
  input  logic          swi_req_i,
  input  logic [1:0]    gate_type_i,
  input  logic [TW-1:0] gate_task_i,
  input  logic          iret_i,
  input  logic          pop_ie_i,
  input  logic [SW-1:0] cur_state_i,
  output logic          grant_o,
  output logic [1:0]    src_o,
  output logic [2:0]    action_o,
  output logic          push_flags_o,
  output logic          push_cs_o,
  output logic          push_ip_o,
  output logic          push_err_o,
  output logic          err_new_stack_o,
  output logic [EW-1:0] err_val_o,
  output logic          pop_frame_o,
  output logic          load_valid_o,
  output logic [SW-1:0] load_state_o,
  output logic          self_err_o,
  output logic          ie_o,
  output logic          nt_o,
  output logic          nmi_blk_o,
  output logic [TW-1:0] cur_task_o,
  output logic [TW-1:0] back_link_o
);
  logic          ie_q, nt_q;
  logic [TW-1:0] cur_q;
  logic          pick, accept, self_err;
  logic [1:0]    src;
  logic          task_sw, tret, pret, clr_ie;
  logic [TW-1:0] a_idx, b_link;
  logic [SW-1:0] a_state;
  logic          a_nt;

  irq_arbiter #(.TW(TW)) u_arb (
    .exc_i     (exc_req_i),
    .nmi_i     (nmi_req_i),
    .intr_i    (intr_req_i),
    .swi_i     (swi_req_i),
    .ie_i      (ie_q),
    .nmi_blk_i (nmi_blk_o),
    .gate_i    (gate_type_i),
    .tgt_i     (gate_task_i),
    .cur_i     (cur_q),
    .pick_o    (pick),
    .src_o     (src),
    .self_err_o(self_err),
    .accept_o  (accept)
  );

  assign task_sw = accept && (gate_type_i == GATE_TASK);
  assign tret    = !pick && iret_i && nt_q;
  assign pret    = !pick && iret_i && !nt_q;
  assign clr_ie  = accept && (gate_type_i != GATE_TRAP) && (gate_type_i != GATE_TASK);
  assign a_idx   = task_sw ? gate_task_i : b_link;

  irq_task_table #(.NTASK(NTASK), .SW(SW)) u_tbl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .s_we_i   (task_sw | tret),
    .s_idx_i  (cur_q),
    .s_state_i(cur_state_i),
    .s_nt_i   (nt_q),
    .l_we_i   (task_sw),
    .l_idx_i  (gate_task_i),
    .l_val_i  (cur_q),
    .a_idx_i  (a_idx),
    .a_state_o(a_state),
    .a_nt_o   (a_nt),
    .b_idx_i  (cur_q),
    .b_link_o (b_link)
  );

  irq_nest_track #(.DW(DW)) u_nest (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .enter_i    (accept),
    .nmi_enter_i(accept && (src == SRC_NMI)),
    .leave_i    (pret | tret),
    .nmi_blk_o  (nmi_blk_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q  <= 1'b0;
      nt_q  <= 1'b0;
      cur_q <= '0;
    end else begin
      if (clr_ie)    ie_q <= 1'b0;
      else if (pret) ie_q <= pop_ie_i;
      if (task_sw) begin
        nt_q  <= 1'b1;
        cur_q <= gate_task_i;
      end else if (tret) begin
        nt_q  <= a_nt;
        cur_q <= b_link;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_o         <= 1'b0;
      src_o           <= '0;
      action_o        <= ACT_NONE;
      push_flags_o    <= 1'b0;
      push_cs_o       <= 1'b0;
      push_ip_o       <= 1'b0;
      push_err_o      <= 1'b0;
      err_new_stack_o <= 1'b0;
      err_val_o       <= '0;
      pop_frame_o     <= 1'b0;
      load_valid_o    <= 1'b0;
      load_state_o    <= '0;
      self_err_o      <= 1'b0;
    end else begin
      grant_o         <= accept;
      src_o           <= accept ? src : '0;
      push_flags_o    <= accept && !task_sw;
      push_cs_o       <= accept && !task_sw;
      push_ip_o       <= accept && !task_sw;
      push_err_o      <= accept && (src == SRC_EXC) && exc_has_err_i;
      err_new_stack_o <= task_sw && (src == SRC_EXC) && exc_has_err_i;
      err_val_o       <= (accept && (src == SRC_EXC) && exc_has_err_i) ? exc_err_i : '0;
      pop_frame_o     <= pret;
      load_valid_o    <= task_sw | tret;
      load_state_o    <= (task_sw | tret) ? a_state : '0;
      self_err_o      <= self_err;
      if (task_sw)     action_o <= ACT_TASK;
      else if (accept) action_o <= ACT_GATE;
      else if (tret)   action_o <= ACT_TRET;
      else if (pret)   action_o <= ACT_PRET;
      else             action_o <= ACT_NONE;
    end
  end

  assign ie_o        = ie_q;
  assign nt_o        = nt_q;
  assign cur_task_o  = cur_q;
  assign back_link_o = b_link;
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
  parameter int TW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    gate_type_i,
  input logic          grant_o,
  input logic [1:0]    src_o,
  input logic [2:0]    action_o,
  input logic          push_flags_o,
  input logic          pop_frame_o,
  input logic          load_valid_o,
  input logic          self_err_o,
  input logic          ie_o,
  input logic          nt_o,
  input logic          nmi_blk_o,
  input logic [TW-1:0] cur_task_o
);
  AST_INTR_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && src_o == 2'd2) |-> $past(ie_o)); // R2
  AST_INT_GATE_CLEARS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && $past(gate_type_i) == 2'd0) |-> !ie_o); // R3
  AST_TRAP_KEEPS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && $past(gate_type_i) == 2'd1) |-> (ie_o == $past(ie_o))); // R3
  AST_NMI_SETS_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && src_o == 2'd1) |-> nmi_blk_o); // R4
  AST_NMI_NOT_WHILE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && src_o == 2'd1) |-> !$past(nmi_blk_o)); // R4
  AST_GATE_PUSHES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (action_o == 3'd1) |-> (push_flags_o && !load_valid_o)); // R5
  AST_TASK_SETS_NT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (action_o == 3'd2) |-> (nt_o && cur_task_o != $past(cur_task_o))); // R6
  AST_PRET_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_frame_o |-> (!load_valid_o && !grant_o)); // R8
  AST_SELF_NO_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    self_err_o |-> (!grant_o && cur_task_o == $past(cur_task_o) && nt_o == $past(nt_o))); // R11
endmodule

bind irq_dispatch_ctrl irq_dispatch_chk #(.TW(TW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gate_type_i (gate_type_i),
  .grant_o     (grant_o),
  .src_o       (src_o),
  .action_o    (action_o),
  .push_flags_o(push_flags_o),
  .pop_frame_o (pop_frame_o),
  .load_valid_o(load_valid_o),
  .self_err_o  (self_err_o),
  .ie_o        (ie_o),
  .nt_o        (nt_o),
  .nmi_blk_o   (nmi_blk_o),
  .cur_task_o  (cur_task_o)
);

// File: tb/sim_irq_dispatch_ctrl.sv
`timescale 1ns/100ps
module sim_irq_dispatch_ctrl;
  localparam int NTASK = 8;
  localparam int SW = 16;
  localparam int EW = 16;
  localparam int TW = 3;
  localparam int DMAX = 15;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic exc, has_err, nmi, intr, swi, iret, pop_ie;
  logic [EW-1:0] err_code;
  logic [1:0] gate;
  logic [TW-1:0] tgt;
  logic [SW-1:0] cstate;

  logic grant, push_flags, push_cs, push_ip, push_err, err_new, pop_frame, load_valid, self_err;
  logic ie, nt, blk;
  logic [1:0] src;
  logic [2:0] action;
  logic [EW-1:0] err_val;
  logic [SW-1:0] load_state;
  logic [TW-1:0] cur_task, back_link;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  irq_dispatch_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .exc_req_i(exc), .exc_has_err_i(has_err), .exc_err_i(err_code),
    .nmi_req_i(nmi), .intr_req_i(intr), .swi_req_i(swi), .gate_type_i(gate), .gate_task_i(tgt),
    .iret_i(iret), .pop_ie_i(pop_ie), .cur_state_i(cstate),
    .grant_o(grant), .src_o(src), .action_o(action), .push_flags_o(push_flags), .push_cs_o(push_cs),
    .push_ip_o(push_ip), .push_err_o(push_err), .err_new_stack_o(err_new), .err_val_o(err_val),
    .pop_frame_o(pop_frame), .load_valid_o(load_valid), .load_state_o(load_state), .self_err_o(self_err),
    .ie_o(ie), .nt_o(nt), .nmi_blk_o(blk), .cur_task_o(cur_task), .back_link_o(back_link)
  );

  // reference model state
  logic [SW-1:0] m_st [NTASK];
  logic          m_nt [NTASK];
  logic [TW-1:0] m_ln [NTASK];
  logic m_ie, m_ntr, m_blk;
  logic [TW-1:0] m_cur;
  int m_depth, m_mark;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NTASK; i++) begin m_st[i] = '0; m_nt[i] = 1'b0; m_ln[i] = '0; end
    m_ie = 0; m_ntr = 0; m_blk = 0; m_cur = '0; m_depth = 0; m_mark = 0;
  endtask

  task automatic idle_in();
    exc = 0; has_err = 0; nmi = 0; intr = 0; swi = 0; iret = 0; pop_ie = 0;
    err_code = '0; gate = 2'd0; tgt = '0; cstate = '0;
  endtask

  // one clock with model prediction and full output compare
  task automatic step();
    logic [3:0] ok;
    logic pick, self, acc, tsw, tret, pret;
    logic [1:0] s;
    logic e_perr, e_new;
    logic [2:0] e_act;
    logic [SW-1:0] e_load;
    logic [TW-1:0] lk;
    ok = {swi, intr & m_ie, nmi & ~m_blk, exc};
    pick = |ok;
    s = ok[0] ? 2'd0 : ok[1] ? 2'd1 : ok[2] ? 2'd2 : 2'd3;
    self = pick && gate == 2'd2 && tgt == m_cur;
    acc = pick && !self;
    tsw = acc && gate == 2'd2;
    tret = !pick && iret && m_ntr;
    pret = !pick && iret && !m_ntr;
    e_perr = acc && s == 2'd0 && has_err;
    e_new = e_perr && tsw;
    e_act = tsw ? 3'd2 : acc ? 3'd1 : tret ? 3'd4 : pret ? 3'd3 : 3'd0;
    lk = m_ln[m_cur];
    e_load = tsw ? m_st[tgt] : tret ? m_st[lk] : '0;
    // next state
    if (acc && gate != 2'd1 && gate != 2'd2) m_ie = 0;
    else if (pret) m_ie = pop_ie;
    if (tsw) begin
      m_st[m_cur] = cstate; m_nt[m_cur] = m_ntr; m_ln[tgt] = m_cur; m_ntr = 1; m_cur = tgt;
    end else if (tret) begin
      m_st[m_cur] = cstate; m_nt[m_cur] = m_ntr; m_ntr = m_nt[lk]; m_cur = lk;
    end
    if (acc) begin
      if (s == 2'd1) begin m_blk = 1; m_mark = m_depth; end
      if (m_depth != DMAX) m_depth++;
    end else if (pret || tret) begin
      if (m_blk && m_depth == m_mark + 1) m_blk = 0;
      if (m_depth != 0) m_depth--;
    end
    @(posedge clk);
    #1;
    chk("R1", "grant_o", 32'(grant), 32'(acc));
    chk("R1", "src_o", 32'(src), acc ? 32'(s) : 0);
    chk("R3", "ie_o", 32'(ie), 32'(m_ie));
    chk("R4", "nmi_blk_o", 32'(blk), 32'(m_blk));
    chk("R5", "push_frame", 32'({push_flags, push_cs, push_ip}), (acc && !tsw) ? 32'h7 : 0);
    chk("R6", "load_valid_o", 32'(load_valid), 32'(tsw | tret));
    chk("R6", "load_state_o", 32'(load_state), 32'(e_load));
    chk("R6", "cur_task_o", 32'(cur_task), 32'(m_cur));
    chk("R6", "nt_o", 32'(nt), 32'(m_ntr));
    chk("R6", "back_link_o", 32'(back_link), 32'(m_ln[m_cur]));
    chk("R7", "push_err", 32'({push_err, err_new}), 32'({e_perr, e_new}));
    chk("R7", "err_val_o", 32'(err_val), e_perr ? 32'(err_code) : 0);
    chk("R8", "pop_frame_o", 32'(pop_frame), 32'(pret));
    chk("R9", "action_o", 32'(action), 32'(e_act));
    chk("R11", "self_err_o", 32'(self_err), 32'(self));
    @(negedge clk);
    idle_in();
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    idle_in();
    model_reset();
    #12 rst_ni = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk("R13", "reset flags", 32'({ie, nt, blk, grant, pop_frame, load_valid}), 0);
    chk("R13", "reset task", 32'(cur_task), 0);

    intr = 1; step();                                      // INTR masked
    chk("R2", "intr masked", 32'(grant), 0);
    iret = 1; pop_ie = 1; step();                          // procedure return sets IE
    chk("R8", "ie from pop", 32'(ie), 1);
    intr = 1; gate = 2'd1; step();                         // trap gate keeps IE
    chk("R3", "trap keeps ie", 32'({grant, ie}), 32'h3);
    nmi = 1; intr = 1; gate = 2'd0; step();                // NMI beats INTR, int gate clears IE
    chk("R1", "nmi over intr", 32'(src), 1);
    chk("R3", "int gate clears ie", 32'(ie), 0);
    nmi = 1; step();
    chk("R4", "nmi blocked", 32'(grant), 0);
    exc = 1; swi = 1; nmi = 1; gate = 2'd1; step();        // exception inside NMI handler
    chk("R2", "exc during block", 32'({grant, src}), 32'h4);
    iret = 1; step();
    chk("R8", "inner return keeps block", 32'(blk), 1);
    iret = 1; step();
    chk("R8", "nmi exit clears block", 32'(blk), 0);
    exc = 1; has_err = 1; err_code = 16'hBEEF; gate = 2'd2; tgt = 3'd3; cstate = 16'hA5A5; step();
    chk("R7", "err to new stack", 32'({push_err, err_new, err_val}), 32'h3BEEF);
    chk("R6", "switched", 32'({cur_task, nt, back_link}), 32'({3'd3, 1'b1, 3'd0}));
    swi = 1; gate = 2'd2; tgt = 3'd3; step();
    chk("R11", "self target", 32'({self_err, grant}), 32'h2);
    iret = 1; cstate = 16'h1234; step();
    chk("R9", "task return", 32'({action, cur_task, nt}), 32'({3'd4, 3'd0, 1'b0}));
    chk("R9", "return load", 32'(load_state), 32'h A5A5);
    swi = 1; gate = 2'd2; tgt = 3'd3; step();
    chk("R10", "resume state", 32'(load_state), 32'h1234);
    exc = 1; gate = 2'd1; iret = 1; step();
    chk("R12", "iret ignored", 32'({pop_frame, action}), 32'h1);
    chk("R12", "task kept", 32'({cur_task, nt}), 32'({3'd3, 1'b1}));

    for (int k = 0; k < 1500; k++) begin
      exc = ($urandom % 10) == 0;
      has_err = $urandom % 2;
      err_code = 16'($urandom);
      nmi = ($urandom % 7) == 0;
      intr = ($urandom % 3) == 0;
      swi = ($urandom % 10) == 0;
      iret = ($urandom % 3) != 0;
      pop_ie = $urandom % 2;
      gate = 2'($urandom);
      tgt = 3'($urandom);
      cstate = 16'($urandom);
      step();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule